// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Interlock Generator

This block turns the two non-inverting commands of each inverter leg, one for the upper switch and one for the lower switch, into the two gate enables for that leg. It never enables both switches of a leg at once. When both commands are asserted, it drops both enables. After either switch of a leg turns off, it holds the other switch off for a minimum number of clock cycles. It adds that gap only when the host's own gap is shorter than the minimum. A host gap that is already long enough reaches the outputs unchanged.

Each leg has one registered output stage, so both enables follow their commands with the same single-cycle latency. The minimum gap, `DT_CYCLES`, is a parameter counted in cycles of the block clock; for example, 29 cycles at 100 MHz gives roughly 290 ns. The number of legs is also a parameter and defaults to three, one per phase of a three-phase bridge. The legs do not interact.

Top module: `dtg_bridge`

## Requirements
- R1: Each enable follows its own command with a latency of one clock cycle. Command pair (upper, lower) = 10 raises only the upper enable, 01 raises only the lower enable, and 00 clears both enables.
- R2: Command pair 11 clears both enables of that leg on the next cycle. The two enables of a leg are never high in the same cycle.
- R3: After either enable of a leg falls, the opposite enable of that leg stays low for at least `DT_CYCLES` consecutive cycles. The opposite enable then rises in exactly the first cycle that this rule allows.
- R4: When the host leaves both commands low for `DT_CYCLES` cycles or more between one command falling and the other rising, the outputs reproduce that gap exactly, with no stretching.
- R5: The inserted gap has the same length for the upper-off-to-lower-on handover as for the lower-off-to-upper-on handover. This holds both for a direct swap of commands and for a swap with a short host gap.
- R6: An enable that falls and is commanded back on, with no opposite enable in between, rises again on the next cycle with no gap. The gap count restarts from the following fall.
- R7: If a leg sits at 11 and one command is then dropped, the remaining enable rises only once `DT_CYCLES` cycles have passed since the last enable of that leg fell. It rises at once if that interval has already elapsed.
- R8: While `rst_n` is low at a clock edge, all enables are low whatever the commands. After reset, a leg's gap is treated as already elapsed, so the first command takes effect one cycle later.
- R9: Each leg behaves independently of the commands applied to the other legs.
- R10: An isolated command pulse of N cycles gives an enable pulse of exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| hin | input | N_PHASE | Upper-switch command per leg, active high |
| lin | input | N_PHASE | Lower-switch command per leg, active high |
| ho | output | N_PHASE | Upper-switch gate enable per leg, active high |
| lo | output | N_PHASE | Lower-switch gate enable per leg, active high |

## Verification
The hardest case to reach is an enable that turns back on while the gap count from its own fall is still running. The counter is busy in that situation, yet it must not hold the returning side back, and it must restart cleanly for the handover that follows. The stimulus reaches this state by dropping the upper command for one cycle, restoring it, and then swapping to the lower command. It also passes through the 11 state with the count still running and then releases one command. This exposes both the cleared count and the waiting count at the ports.

// File: rtl/dtg_pkg.sv
// Shared types for the dead-time and interlock generator.
// Assumes: one bit per switch command, active high.
package dtg_pkg;

    // Which switch of a leg went off most recently
    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } side_e;

    // Decoded, mutually exclusive request of one leg
    typedef struct packed {
        logic want_hi;
        logic want_lo;
    } leg_req_t;

endpackage

// File: rtl/dtg_cmd_decode.sv
// Command decoder: applies the cross-conduction truth table to one leg.
// 10 -> upper only, 01 -> lower only, 00 and 11 -> neither.
// Assumes: commands are already filtered and synchronous to the block clock.
module dtg_cmd_decode
    import dtg_pkg::*;
(
    input  logic     cmd_hi,
    input  logic     cmd_lo,
    output leg_req_t req
);

    // Purpose: a request survives only when its partner command is idle
    always_comb begin
        req.want_hi = cmd_hi & ~cmd_lo;
        req.want_lo = cmd_lo & ~cmd_hi;
    end

endmodule

// File: rtl/dtg_gap_timer.sv
// Gap timer for one leg: counts the off interval after an enable falls and
// remembers which side fell. It reports "quiet" once the interval is spent.
// A rise clears the count; the next fall starts it again from the top.
// Assumes: the two enables never fall in the same cycle (they are exclusive).
module dtg_gap_timer
    import dtg_pkg::*;
#(
    parameter int DT_CYCLES = 29
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fall_hi,
    input  logic  fall_lo,
    input  logic  rise_any,
    output logic  quiet,
    output side_e last_off
);

    localparam int CNT_W = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
    // The fall cycle itself is the first cycle of the gap
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DT_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Purpose: load on a fall, clear on a rise, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            last_off <= SIDE_LOW;
        end else if (fall_hi || fall_lo) begin
            remain   <= LOAD;
            last_off <= fall_hi ? SIDE_HIGH : SIDE_LOW;
        end else if (rise_any) begin
            remain   <= '0;
        end else if (remain != '0) begin
            remain   <= remain - 1'b1;
        end
    end

    // Purpose: the interval has elapsed when nothing is left to count
    always_comb quiet = (remain == '0);

endmodule

// File: rtl/dtg_leg.sv
// One inverter leg: decodes the command pair, gates each turn-on behind the
// opposite enable and the gap timer, and registers both enables so that the
// two channels share the same one-cycle latency.
// Assumes: DT_CYCLES >= 1.
module dtg_leg
    import dtg_pkg::*;
#(
    parameter int DT_CYCLES = 29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic en_hi,
    output logic en_lo
);

    leg_req_t req;
    logic     grant_hi;
    logic     grant_lo;
    logic     fall_hi;
    logic     fall_lo;
    logic     rise_any;
    logic     quiet;
    side_e    last_off;

    dtg_cmd_decode u_dec (
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .req    (req)
    );

    // Purpose: a side may be on if asked, its partner is off, and either the
    // gap has elapsed or this same side was the one that went off last
    always_comb begin
        grant_hi = req.want_hi & ~en_lo & (quiet | (last_off == SIDE_HIGH));
        grant_lo = req.want_lo & ~en_hi & (quiet | (last_off == SIDE_LOW));
    end

    // Purpose: detect the edges the next clock will produce on the enables
    always_comb begin
        fall_hi  = en_hi & ~grant_hi;
        fall_lo  = en_lo & ~grant_lo;
        rise_any = (~en_hi & grant_hi) | (~en_lo & grant_lo);
    end

    dtg_gap_timer #(
        .DT_CYCLES (DT_CYCLES)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_hi  (fall_hi),
        .fall_lo  (fall_lo),
        .rise_any (rise_any),
        .quiet    (quiet),
        .last_off (last_off)
    );

    // Purpose: output register shared in structure by both channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_hi <= 1'b0;
            en_lo <= 1'b0;
        end else begin
            en_hi <= grant_hi;
            en_lo <= grant_lo;
        end
    end

endmodule

// File: rtl/dtg_bridge.sv
// Top level: N_PHASE identical, independent legs of dead-time and interlock
// generation for a bridge inverter.
// Assumes: commands synchronous to clk; DT_CYCLES >= 1.
module dtg_bridge #(
    parameter int N_PHASE   = 3,
    parameter int DT_CYCLES = 29
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hin,
    input  logic [N_PHASE-1:0] lin,
    output logic [N_PHASE-1:0] ho,
    output logic [N_PHASE-1:0] lo
);

    // Purpose: one leg per phase
    for (genvar g = 0; g < N_PHASE; g++) begin : g_leg
        dtg_leg #(
            .DT_CYCLES (DT_CYCLES)
        ) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_hi (hin[g]),
            .cmd_lo (lin[g]),
            .en_hi  (ho[g]),
            .en_lo  (lo[g])
        );
    end

endmodule

// File: rtl/dtg_bridge_chk.sv
// Property checker for dtg_bridge, attached by bind.
// For each leg it keeps its own count of cycles since each enable was last
// high, saturating at DT_CYCLES, and checks turn-ons against that count.
module dtg_bridge_chk #(
    parameter int N_PHASE   = 3,
    parameter int DT_CYCLES = 29
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] hin,
    input logic [N_PHASE-1:0] lin,
    input logic [N_PHASE-1:0] ho,
    input logic [N_PHASE-1:0] lo
);

    localparam int RW = $clog2(DT_CYCLES + 1);
    localparam logic [RW-1:0] SAT = RW'(DT_CYCLES);

    for (genvar g = 0; g < N_PHASE; g++) begin : g_chk
        logic [RW-1:0] lo_idle;
        logic [RW-1:0] hi_idle;
        logic          ho_d;
        logic          lo_d;

        // Purpose: independent off-time counters and previous-cycle enables
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_idle <= SAT;
                hi_idle <= SAT;
                ho_d    <= 1'b0;
                lo_d    <= 1'b0;
            end else begin
                lo_idle <= lo[g] ? '0 : ((lo_idle == SAT) ? SAT : lo_idle + 1'b1);
                hi_idle <= ho[g] ? '0 : ((hi_idle == SAT) ? SAT : hi_idle + 1'b1);
                ho_d    <= ho[g];
                lo_d    <= lo[g];
            end
        end

        AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
            !(ho[g] && lo[g])); // R2

        AST_BOTH_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (hin[g] && lin[g]) |=> (!ho[g] && !lo[g])); // R2

        AST_HI_FOLLOWS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !hin[g] |=> !ho[g]); // R1

        AST_LO_FOLLOWS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !lin[g] |=> !lo[g]); // R1

        AST_HI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (ho[g] && !ho_d) |-> (lo_idle >= SAT)); // R3

        AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (lo[g] && !lo_d) |-> (hi_idle >= SAT)); // R5
    end

endmodule

bind dtg_bridge dtg_bridge_chk #(
    .N_PHASE   (N_PHASE),
    .DT_CYCLES (DT_CYCLES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hin   (hin),
    .lin   (lin),
    .ho    (ho),
    .lo    (lo)
);

// File: tb/sim_dtg_bridge.sv
// Scoreboard bench: the driver applies commands on the falling edge and
// queues the enables expected after the next rising edge. The monitor pops
// the queue shortly after each rising edge and compares.
module sim_dtg_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 3;
    localparam int DT         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hin = '0;
    logic [NP-1:0] lin = '0;
    logic [NP-1:0] ho;
    logic [NP-1:0] lo;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [NP-1:0] eh;
        logic [NP-1:0] el;
        string         tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dtg_bridge #(
        .N_PHASE   (NP),
        .DT_CYCLES (DT)
    ) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .hin   (hin),
        .lin   (lin),
        .ho    (ho),
        .lo    (lo)
    );

    // Apply one command set for n cycles and queue the expected enables
    task automatic run(input logic [NP-1:0] h, input logic [NP-1:0] l,
                       input int n, input logic [NP-1:0] eh,
                       input logic [NP-1:0] el, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            @(negedge clk);
            hin = h;
            lin = l;
            it.eh = eh;
            it.el = el;
            it.tag = tag;
            sb.push_back(it);
        end
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (ho !== it.eh || lo !== it.el) begin
                    errors++;
                    $display("FAIL %s: ho=%b lo=%b expected ho=%b lo=%b",
                             it.tag, ho, lo, it.eh, it.el);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: ran out of time, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R8: reset holds enables low even with commands present
        hin = 3'b101;
        lin = 3'b010;
        repeat (3) @(negedge clk);
        checks++;
        if (ho !== '0 || lo !== '0) begin
            errors++;
            $display("FAIL R8: ho=%b lo=%b expected ho=000 lo=000", ho, lo);
        end
        hin = '0;
        lin = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8/R1/R10: counter expired at reset, upper follows a 3-cycle pulse
        run(3'b001, 3'b000, 3, 3'b001, 3'b000, "R8 R10 upper pulse");
        run(3'b000, 3'b000, 6, 3'b000, 3'b000, "R1 idle");
        // R4: a 6-cycle host gap passes unchanged
        run(3'b000, 3'b001, 3, 3'b000, 3'b001, "R4 long gap lower on");
        // R3: a 1-cycle host gap is stretched to DT
        run(3'b000, 3'b000, 1, 3'b000, 3'b000, "R3 short gap");
        run(3'b001, 3'b000, 3, 3'b000, 3'b000, "R3 gap held");
        run(3'b001, 3'b000, 5, 3'b001, 3'b000, "R3 upper after gap");
        // R5: direct swaps in both directions give the same gap
        run(3'b000, 3'b001, 4, 3'b000, 3'b000, "R5 hi-to-lo gap");
        run(3'b000, 3'b001, 4, 3'b000, 3'b001, "R5 lower on");
        run(3'b001, 3'b000, 4, 3'b000, 3'b000, "R5 lo-to-hi gap");
        run(3'b001, 3'b000, 4, 3'b001, 3'b000, "R5 upper on");
        // R2/R7: 11 with the count running, then release the upper command
        run(3'b001, 3'b001, 3, 3'b000, 3'b000, "R2 both commanded");
        run(3'b000, 3'b001, 1, 3'b000, 3'b000, "R7 waits for expiry");
        run(3'b000, 3'b001, 4, 3'b000, 3'b001, "R7 lower on");
        // R7: from an expired gap, 11 then 10 turns on at once
        run(3'b000, 3'b000, 6, 3'b000, 3'b000, "R1 idle");
        run(3'b001, 3'b001, 3, 3'b000, 3'b000, "R2 both from idle");
        run(3'b001, 3'b000, 3, 3'b001, 3'b000, "R7 immediate after expiry");
        // R6: same-side return is immediate, the count restarts on next fall
        run(3'b000, 3'b000, 1, 3'b000, 3'b000, "R6 upper off");
        run(3'b001, 3'b000, 2, 3'b001, 3'b000, "R6 upper back at once");
        run(3'b000, 3'b001, 4, 3'b000, 3'b000, "R6 restarted gap");
        run(3'b000, 3'b001, 2, 3'b000, 3'b001, "R6 lower on");
        // R9: legs are independent
        run(3'b000, 3'b000, 6, 3'b000, 3'b000, "R9 idle");
        run(3'b101, 3'b010, 3, 3'b101, 3'b010, "R9 mixed legs");
        run(3'b010, 3'b101, 4, 3'b000, 3'b000, "R9 all swap gap");
        run(3'b010, 3'b101, 2, 3'b010, 3'b101, "R9 all swapped");
        run(3'b000, 3'b101, 2, 3'b000, 3'b101, "R9 one leg off");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule